// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block sits between two parallel buses, called the A side and the B side, and moves data across them in either direction. The data path is cut into independent byte-wide sections. Every section carries two separate paths, one from A toward B and one from B toward A. Each path has a storage element that either passes its input straight through or keeps a value it captured earlier. The path drives the far side only when it is selected and its drive is allowed.

All six controls of a section are active low. The chip select of a path acts as a master switch. While it is deasserted, the path's store is frozen and its outputs are released, whatever the other two controls do. The capture control chooses between pass-through and hold. The drive control decides only whether the far side is driven. Tri-state pins appear as separate input, output and per-bit drive-enable vectors, so the block stays plain synchronous logic. The store samples on the rising clock edge. While a path is in pass-through, its output follows the input combinationally.

Top module: `latched_bus_xcvr`

## Requirements
- R1: An active-low reset clears the store of every path in every section to zero. A path that is then selected and driving, with capture deasserted, presents zero on its output.
- R2: While a section's A-to-B select and capture controls are both low, its slice of `b_out` equals the same slice of `a_in` in the same cycle.
- R3: Once the A-to-B capture control goes high with select low, the slice of `b_out` holds the `a_in` value sampled at the last rising clock edge at which select and capture were both low. Later changes of `a_in` do not move it.
- R4: While the A-to-B select is high, the slice of `b_oe` is all zero and the store keeps its value, whatever the capture and drive controls do. After select returns low with capture high, the old value appears.
- R5: Every bit of a section's slice of `b_oe` is 1 exactly when both the A-to-B select and drive controls of that section are low. Otherwise every bit is 0.
- R6: With the A-to-B drive control high, the outputs are released, but the store still follows the capture control. A value captured while not driving appears once drive is enabled again.
- R7: The B-to-A path of each section follows the same rules as R1 to R6, using its own three controls, with `b_in` as its source and `a_out`/`a_oe` as its output.
- R8: Sections are independent. Section s covers bits [8s+7:8s], and its controls are bit s of each control vector. Activity in one section never changes the outputs or drive enables of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores sample on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all stores |
| ab_sel_n | input | SECTIONS | A-to-B select per section, active low |
| ab_cap_n | input | SECTIONS | A-to-B capture control per section, low = pass-through |
| ab_drv_n | input | SECTIONS | A-to-B drive control per section, active low |
| ba_sel_n | input | SECTIONS | B-to-A select per section, active low |
| ba_cap_n | input | SECTIONS | B-to-A capture control per section, low = pass-through |
| ba_drv_n | input | SECTIONS | B-to-A drive control per section, active low |
| a_in | input | LANE_W*SECTIONS | Data arriving on the A side |
| a_out | output | LANE_W*SECTIONS | Data to drive onto the A side |
| a_oe | output | LANE_W*SECTIONS | Per-bit drive enable for the A side |
| b_in | input | LANE_W*SECTIONS | Data arriving on the B side |
| b_out | output | LANE_W*SECTIONS | Data to drive onto the B side |
| b_oe | output | LANE_W*SECTIONS | Per-bit drive enable for the B side |

## Verification
The case hardest to reach from the ports is a value captured while the path is not driving. Seeing it takes three steps: capture with drive released, close the store, then re-enable drive while the input holds a different value. The stimulus table walks one path through that order with distinct data at each step, so a store that ignored capture while not driving would show the wrong byte. The same goes for a store that only loaded while driving. Cross-section independence gets a similar treatment. One section is frozen on a known byte while its own input changes, and the neighbouring section runs in pass-through with changing data.

// File: rtl/latched_bus_xcvr_pkg.sv
package latched_bus_xcvr_pkg;

    typedef enum logic [1:0] {
        PATH_OFF  = 2'd0,
        PATH_HOLD = 2'd1,
        PATH_PASS = 2'd2
    } path_mode_e;

    function automatic path_mode_e decode_mode(input logic sel_n, input logic cap_n);
        if (sel_n)      return PATH_OFF;
        else if (cap_n) return PATH_HOLD;
        else            return PATH_PASS;
    endfunction

endpackage

// File: rtl/latched_bus_xcvr_path.sv
module latched_bus_xcvr_path
    import latched_bus_xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              cap_n,
    input  logic              drv_n,
    input  logic [LANE_W-1:0] src,
    output logic [LANE_W-1:0] dst,
    output logic [LANE_W-1:0] dst_oe
);

    typedef struct packed {
        logic [LANE_W-1:0] held;
    } path_state_t;

    path_state_t st_d, st_q;
    path_mode_e  mode;

    always_comb begin
        mode = decode_mode(sel_n, cap_n);
        st_d = st_q;
        dst  = st_q.held;
        case (mode)
            PATH_PASS: begin
                st_d.held = src;
                dst       = src;
            end
            PATH_HOLD: st_d.held = st_q.held;
            default:   st_d.held = st_q.held;
        endcase
        dst_oe = {LANE_W{(mode != PATH_OFF) && !drv_n}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/latched_bus_xcvr_section.sv
module latched_bus_xcvr_section #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ab_sel_n,
    input  logic              ab_cap_n,
    input  logic              ab_drv_n,
    input  logic              ba_sel_n,
    input  logic              ba_cap_n,
    input  logic              ba_drv_n,
    input  logic [LANE_W-1:0] a_in,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] a_oe,
    input  logic [LANE_W-1:0] b_in,
    output logic [LANE_W-1:0] b_out,
    output logic [LANE_W-1:0] b_oe
);

    latched_bus_xcvr_path #(.LANE_W(LANE_W)) u_a2b (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (ab_sel_n),
        .cap_n  (ab_cap_n),
        .drv_n  (ab_drv_n),
        .src    (a_in),
        .dst    (b_out),
        .dst_oe (b_oe)
    );

    latched_bus_xcvr_path #(.LANE_W(LANE_W)) u_b2a (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (ba_sel_n),
        .cap_n  (ba_cap_n),
        .drv_n  (ba_drv_n),
        .src    (b_in),
        .dst    (a_out),
        .dst_oe (a_oe)
    );

endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr #(
    parameter int LANE_W   = 8,
    parameter int SECTIONS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SECTIONS-1:0]        ab_sel_n,
    input  logic [SECTIONS-1:0]        ab_cap_n,
    input  logic [SECTIONS-1:0]        ab_drv_n,
    input  logic [SECTIONS-1:0]        ba_sel_n,
    input  logic [SECTIONS-1:0]        ba_cap_n,
    input  logic [SECTIONS-1:0]        ba_drv_n,
    input  logic [LANE_W*SECTIONS-1:0] a_in,
    output logic [LANE_W*SECTIONS-1:0] a_out,
    output logic [LANE_W*SECTIONS-1:0] a_oe,
    input  logic [LANE_W*SECTIONS-1:0] b_in,
    output logic [LANE_W*SECTIONS-1:0] b_out,
    output logic [LANE_W*SECTIONS-1:0] b_oe
);

    localparam int BUS_W = LANE_W * SECTIONS;

    logic [BUS_W-1:0] a_out_w, a_oe_w, b_out_w, b_oe_w;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        latched_bus_xcvr_section #(.LANE_W(LANE_W)) u_sec (
            .clk      (clk),
            .rst_n    (rst_n),
            .ab_sel_n (ab_sel_n[s]),
            .ab_cap_n (ab_cap_n[s]),
            .ab_drv_n (ab_drv_n[s]),
            .ba_sel_n (ba_sel_n[s]),
            .ba_cap_n (ba_cap_n[s]),
            .ba_drv_n (ba_drv_n[s]),
            .a_in     (a_in[s*LANE_W +: LANE_W]),
            .a_out    (a_out_w[s*LANE_W +: LANE_W]),
            .a_oe     (a_oe_w[s*LANE_W +: LANE_W]),
            .b_in     (b_in[s*LANE_W +: LANE_W]),
            .b_out    (b_out_w[s*LANE_W +: LANE_W]),
            .b_oe     (b_oe_w[s*LANE_W +: LANE_W])
        );
    end

    assign a_out = a_out_w;
    assign a_oe  = a_oe_w;
    assign b_out = b_out_w;
    assign b_oe  = b_oe_w;

endmodule

// File: rtl/latched_bus_xcvr_chk.sv
module latched_bus_xcvr_chk #(
    parameter int LANE_W   = 8,
    parameter int SECTIONS = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [SECTIONS-1:0]        ab_sel_n,
    input logic [SECTIONS-1:0]        ab_cap_n,
    input logic [SECTIONS-1:0]        ab_drv_n,
    input logic [SECTIONS-1:0]        ba_sel_n,
    input logic [SECTIONS-1:0]        ba_cap_n,
    input logic [SECTIONS-1:0]        ba_drv_n,
    input logic [LANE_W*SECTIONS-1:0] a_in,
    input logic [LANE_W*SECTIONS-1:0] a_out,
    input logic [LANE_W*SECTIONS-1:0] a_oe,
    input logic [LANE_W*SECTIONS-1:0] b_in,
    input logic [LANE_W*SECTIONS-1:0] b_out,
    input logic [LANE_W*SECTIONS-1:0] b_oe
);

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        // R2 / R7: pass-through follows the source
        assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_sel_n[s] && !ab_cap_n[s]) |-> b_out[s*LANE_W +: LANE_W] == a_in[s*LANE_W +: LANE_W]);
        assert_ba_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ba_sel_n[s] && !ba_cap_n[s]) |-> a_out[s*LANE_W +: LANE_W] == b_in[s*LANE_W +: LANE_W]);

        // R3: closing the store keeps the last sampled value
        assert_ab_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!ab_sel_n[s] && !ab_cap_n[s]) && !ab_sel_n[s] && ab_cap_n[s])
            |-> b_out[s*LANE_W +: LANE_W] == $past(a_in[s*LANE_W +: LANE_W]));

        // R4: deselected path releases and freezes
        assert_ab_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ab_sel_n[s]) && ab_sel_n[s])
            |-> $stable(b_out[s*LANE_W +: LANE_W]));

        // R5: drive enable covers the whole section or none of it
        assert_ab_drive_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_sel_n[s] && !ab_drv_n[s]) |-> &b_oe[s*LANE_W +: LANE_W]);
        assert_ab_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_sel_n[s] || ab_drv_n[s]) |-> b_oe[s*LANE_W +: LANE_W] == '0);
        assert_ba_drive_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ba_sel_n[s] && !ba_drv_n[s]) |-> &a_oe[s*LANE_W +: LANE_W]);
        assert_ba_drive_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_sel_n[s] || ba_drv_n[s]) |-> a_oe[s*LANE_W +: LANE_W] == '0);
    end

endmodule

bind latched_bus_xcvr latched_bus_xcvr_chk #(.LANE_W(LANE_W), .SECTIONS(SECTIONS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab_sel_n (ab_sel_n),
    .ab_cap_n (ab_cap_n),
    .ab_drv_n (ab_drv_n),
    .ba_sel_n (ba_sel_n),
    .ba_cap_n (ba_cap_n),
    .ba_drv_n (ba_drv_n),
    .a_in     (a_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_in     (b_in),
    .b_out    (b_out),
    .b_oe     (b_oe)
);

// File: tb/latched_bus_xcvr_bench.sv
module latched_bus_xcvr_bench;

    localparam int LANE_W   = 8;
    localparam int SECTIONS = 2;
    localparam int BUS_W    = LANE_W * SECTIONS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SECTIONS-1:0] ab_sel_n = '1, ab_cap_n = '1, ab_drv_n = '1;
    logic [SECTIONS-1:0] ba_sel_n = '1, ba_cap_n = '1, ba_drv_n = '1;
    logic [BUS_W-1:0] a_in = '0, b_in = '0;
    logic [BUS_W-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    latched_bus_xcvr #(.LANE_W(LANE_W), .SECTIONS(SECTIONS)) u_latched_bus_xcvr (
        .clk(clk), .rst_n(rst_n),
        .ab_sel_n(ab_sel_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
        .ba_sel_n(ba_sel_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       sel_n;
        logic       cap_n;
        logic       drv_n;
        logic [7:0] din;
        logic       exp_oe;
        logic       chk_data;
        logic [7:0] exp_data;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t [0:NVEC-1] VECS = '{
        '{4'd1, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b1, 8'h00}, // R1 cleared store
        '{4'd2, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b1, 8'h5A}, // R2 pass
        '{4'd2, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b1, 8'hC3}, // R2 pass
        '{4'd3, 1'b0, 1'b1, 1'b0, 8'h11, 1'b1, 1'b1, 8'hC3}, // R3 held
        '{4'd3, 1'b0, 1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 8'hC3}, // R3 held
        '{4'd4, 1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 8'h00}, // R4 deselected
        '{4'd4, 1'b0, 1'b1, 1'b0, 8'h33, 1'b1, 1'b1, 8'hC3}, // R4 store kept
        '{4'd6, 1'b0, 1'b0, 1'b1, 8'h9E, 1'b0, 1'b0, 8'h00}, // R6 capture, no drive
        '{4'd6, 1'b0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00}, // R6 hold, no drive
        '{4'd6, 1'b0, 1'b1, 1'b0, 8'h02, 1'b1, 1'b1, 8'h9E}, // R6 value shows
        '{4'd5, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00}, // R5 all released
        '{4'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}  // R2 pass zero
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // contention monitor: both directions of one section driving
    always @(negedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < SECTIONS; s++) begin
                if (|a_oe[s*LANE_W +: LANE_W] && |b_oe[s*LANE_W +: LANE_W]) begin
                    failures++;
                    $display("FAIL R5: contention in section %0d got both driving expected one", s);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 reset b_oe", b_oe, 16'h0000);
        check("R1 reset a_oe", a_oe, 16'h0000);

        // R1: B-to-A store of section 1 cleared
        @(negedge clk);
        ba_sel_n[1] = 1'b0; ba_cap_n[1] = 1'b1; ba_drv_n[1] = 1'b0; b_in = 16'hE700;
        #2;
        check("R1 reset ba store", a_out[15:8], 16'h0000);
        check("R1 reset ba drive", a_oe, 16'hFF00);
        @(negedge clk);
        ba_sel_n = '1; ba_drv_n = '1;

        // table walk on section 0, A-to-B
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ab_sel_n[0] = VECS[i].sel_n;
            ab_cap_n[0] = VECS[i].cap_n;
            ab_drv_n[0] = VECS[i].drv_n;
            a_in[7:0]   = VECS[i].din;
            #2;
            checks++;
            if (b_oe[7:0] !== {8{VECS[i].exp_oe}} ||
                (VECS[i].chk_data && b_out[7:0] !== VECS[i].exp_data)) begin
                failures++;
                $display("FAIL R%0d row %0d: got oe=%h data=%h expected oe=%h data=%h",
                         VECS[i].req, i, b_oe[7:0], b_out[7:0],
                         {8{VECS[i].exp_oe}}, VECS[i].exp_data);
            end
            check("R8 section1 idle in walk", b_oe[15:8], 16'h0000);
        end
        @(negedge clk);
        ab_sel_n = '1; ab_cap_n = '1; ab_drv_n = '1;

        // R7: B-to-A on section 1
        @(negedge clk);
        ba_sel_n[1] = 1'b0; ba_cap_n[1] = 1'b0; ba_drv_n[1] = 1'b0; b_in[15:8] = 8'h6C;
        #2;
        check("R7 ba pass", a_out[15:8], 16'h006C);
        check("R7 ba drive", a_oe, 16'hFF00);
        @(negedge clk);
        ba_cap_n[1] = 1'b1; b_in[15:8] = 8'h00;
        #2;
        check("R7 ba held", a_out[15:8], 16'h006C);
        @(negedge clk);
        ba_drv_n[1] = 1'b1;
        #2;
        check("R7 ba released", a_oe, 16'h0000);
        @(negedge clk);
        ba_sel_n = '1; ba_cap_n = '1;

        // R8: section 1 frozen on A5 while section 0 runs
        @(negedge clk);
        ab_sel_n[1] = 1'b0; ab_cap_n[1] = 1'b0; ab_drv_n[1] = 1'b0; a_in[15:8] = 8'hA5;
        @(negedge clk);
        ab_cap_n[1] = 1'b1; a_in[15:8] = 8'h00;
        ab_sel_n[0] = 1'b0; ab_cap_n[0] = 1'b0; ab_drv_n[0] = 1'b0; a_in[7:0] = 8'h3C;
        #2;
        check("R8 both sections", b_out, 16'hA53C);
        check("R8 both drive", b_oe, 16'hFFFF);
        @(negedge clk);
        a_in = 16'h5FC1;
        ab_drv_n[1] = 1'b1;
        #2;
        check("R8 sec1 held sec0 pass", b_out, 16'hA5C1);
        check("R8 sec1 released only", b_oe, 16'h00FF);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule